// File: doc/BRIEF.md
# Dual-Lane SIMD Load and MAC Datapath

This block is a fixed-point execution engine with two identical lanes that take their commands from one stream. Each lane owns a small register file and a 40-bit accumulator. A 64-bit data memory port moves one 32-bit operand per lane in each access. Lane 0 always uses the low half of the addressed word and lane 1 the high half, which is the element that follows. A loop of N words therefore covers 2N packed elements. Complex data fits this layout directly: the real part sits in lane 0 and the imaginary part in lane 1, so one add gives a complex vector sum.

A mode input switches the second lane on or off. With the mode off, only lane 0 executes and nothing in lane 1 changes. Loads come in two forms. Paired loads give each lane its own half of the word. Broadcast loads copy the low half into both lanes. The multiply-accumulate command streams a run of consecutive words, one per cycle. It repeats a programmed number of times, so a filter of N taps finishes in about N/2 iterations when both lanes run. The combined result is presented on a sum output. Commands are accepted one at a time, and only while the engine is idle.

Top module: `simd_pair_dp`

## Requirements
- R1: After reset `cmdReady` is 1, `doneFlag`, `memRe` and `memWe` are 0, `macSum` is 0, and every register of both lanes reads as zero.
- R2: A load with `cmdOp`=0 and `cmdBcast`=0, issued with `simdEn`=1, writes bits [31:0] of the memory word into register `cmdRd` of lane 0 and bits [63:32] into the same register of lane 1.
- R3: A load with `cmdBcast`=1, issued with `simdEn`=1, writes bits [31:0] of the memory word into register `cmdRd` of both lanes.
- R4: A command accepted with `simdEn`=0 executes in lane 0 only, and every lane 1 register keeps its value. This holds for paired loads, broadcast loads and adds.
- R5: A store (`cmdOp`=1) lasts one cycle, with `memWdata` = {lane 1 reg, lane 0 reg}. `memWmask` bit 0 enables bits [31:0] and bit 1 enables bits [63:32]. The mask is 2'b11 in SIMD mode and 2'b01 otherwise, and `memRe` and `memWe` are never high together.
- R6: An add (`cmdOp`=2) sets `cmdRd` = `cmdRa` + `cmdRb` in each active lane, modulo 2^32.
- R7: A multiply-accumulate (`cmdOp`=3) clears both accumulators when it is accepted. It then reads `cmdCount` consecutive words starting at `cmdAddr`, one read per cycle. For each word, each active lane adds signed half[15:0] times signed half[31:16] of its own 32-bit half to its accumulator. `macSum` is the signed sum of both accumulators, and it holds its value while the engine is idle.
- R8: A multiply-accumulate issued with `simdEn`=0 accumulates only the low halves, so `macSum` equals lane 0's dot product.
- R9: `doneFlag` is high for exactly one cycle. For a multiply-accumulate this is the (`cmdCount`+1)-th cycle after acceptance, and for any other command it is the 2nd cycle. A count of zero raises it in the 1st cycle, with no read and `macSum` = 0. Results are visible in the cycle after `doneFlag`.
- R10: `cmdReady` is high only while idle. A `cmdValid` raised while busy is ignored and changes no register.
- R11: Memory reads have one cycle of latency: `memRdata` is taken in the cycle after `memRe`. A load issues exactly one read and a multiply-accumulate issues exactly `cmdCount` reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| simdEn | input | 1 | Second lane enable, sampled when a command is accepted |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Engine idle, command taken this cycle if valid |
| cmdOp | input | 2 | 0 load, 1 store, 2 add, 3 multiply-accumulate |
| cmdBcast | input | 1 | Load form: 1 broadcast, 0 paired |
| cmdRd | input | RIDX_W | Destination register (load, add), source register (store) |
| cmdRa | input | RIDX_W | First add operand |
| cmdRb | input | RIDX_W | Second add operand |
| cmdAddr | input | ADDR_W | Word address (start address for multiply-accumulate) |
| cmdCount | input | CNT_W | Multiply-accumulate iteration count |
| memAddr | output | ADDR_W | Memory word address |
| memRe | output | 1 | Memory read strobe |
| memWe | output | 1 | Memory write strobe |
| memWmask | output | 2 | Per-half write enable |
| memWdata | output | 64 | Store data |
| memRdata | input | 64 | Read data, one cycle after memRe |
| macSum | output | ACC_W+1 | Sum of both lane accumulators |
| doneFlag | output | 1 | One-cycle completion pulse |

## Verification
The bench runs the multiply-accumulate with the second lane on and off, and with counts of one, several and zero. A design that let the high halves leak in with the lane off, or skipped the accumulator clear, would produce a wrong sum. An off-by-one in the loop counter would show as a wrong read count or a late done pulse. Registers are read back only through stores, so the bench can see lane 1 directly. A design that wrote lane 1 with the mode off, broadcast the wrong half, or wrote the high half during a non-SIMD store would leave a wrong memory word. The bench also covers 32-bit add wrap-around and a command raised while busy, which a careless acceptance rule would execute.

// File: rtl/simd_pair_pkg.sv
package simd_pair_pkg;

  localparam int LANES  = 2;
  localparam int LANE_W = 32;
  localparam int HALF_W = LANE_W / 2;
  localparam int WORD_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_ADD   = 2'd2,
    OP_MAC   = 2'd3
  } cmd_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } ctrl_state_e;

  // strobes from sequencer to lane datapath
  typedef struct packed {
    logic simd;
    logic bcast;
    logic ldWr;
    logic addWr;
    logic macStep;
    logic accClr;
  } lane_strobe_t;

endpackage

// File: rtl/simd_pair_ctrl.sv
module simd_pair_ctrl
  import simd_pair_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8,
  localparam int RIDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              simdEn,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdOp,
  input  logic              cmdBcast,
  input  logic [RIDX_W-1:0] cmdRd,
  input  logic [RIDX_W-1:0] cmdRa,
  input  logic [RIDX_W-1:0] cmdRb,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [CNT_W-1:0]  cmdCount,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [1:0]        memWmask,
  output logic              doneFlag,
  output lane_strobe_t      strobe,
  output logic [RIDX_W-1:0] rdIdx,
  output logic [RIDX_W-1:0] raIdx,
  output logic [RIDX_W-1:0] rbIdx
);

  ctrl_state_e       state;
  cmd_op_e           opReg;
  logic              simdReg;
  logic              bcastReg;
  logic [ADDR_W-1:0] baseReg;
  logic [ADDR_W-1:0] iterIdx;
  logic [CNT_W-1:0]  loopCnt;
  logic              ldPend;
  logic              macPend;
  logic              accept;
  cmd_op_e           inOp;

  assign inOp     = cmd_op_e'(cmdOp);
  assign cmdReady = (state == ST_IDLE);
  assign accept   = cmdValid && cmdReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      opReg    <= OP_LOAD;
      simdReg  <= 1'b0;
      bcastReg <= 1'b0;
      baseReg  <= '0;
      iterIdx  <= '0;
      loopCnt  <= '0;
      rdIdx    <= '0;
      raIdx    <= '0;
      rbIdx    <= '0;
      ldPend   <= 1'b0;
      macPend  <= 1'b0;
    end else begin
      ldPend  <= (state == ST_RUN) && (opReg == OP_LOAD);
      macPend <= (state == ST_RUN) && (opReg == OP_MAC);
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            opReg    <= inOp;
            simdReg  <= simdEn;
            bcastReg <= cmdBcast;
            baseReg  <= cmdAddr;
            rdIdx    <= cmdRd;
            raIdx    <= cmdRa;
            rbIdx    <= cmdRb;
            iterIdx  <= '0;
            if (inOp == OP_MAC) begin
              loopCnt <= cmdCount;
              state   <= (cmdCount == '0) ? ST_TAIL : ST_RUN;
            end else begin
              loopCnt <= CNT_W'(1);
              state   <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          iterIdx <= iterIdx + ADDR_W'(1);
          loopCnt <= loopCnt - CNT_W'(1);
          if (loopCnt == CNT_W'(1)) state <= ST_TAIL;
        end
        ST_TAIL: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign memAddr  = baseReg + iterIdx;
  assign memRe    = (state == ST_RUN) && ((opReg == OP_LOAD) || (opReg == OP_MAC));
  assign memWe    = (state == ST_RUN) && (opReg == OP_STORE);
  assign memWmask = {simdReg, 1'b1};
  assign doneFlag = (state == ST_TAIL);

  always_comb begin
    strobe.simd    = simdReg;
    strobe.bcast   = bcastReg;
    strobe.ldWr    = ldPend;
    strobe.macStep = macPend;
    strobe.addWr   = (state == ST_RUN) && (opReg == OP_ADD);
    strobe.accClr  = accept && (inOp == OP_MAC);
  end

endmodule

// File: rtl/simd_pair_lanes.sv
module simd_pair_lanes
  import simd_pair_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int ACC_W = 40,
  localparam int RIDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  lane_strobe_t      strobe,
  input  logic [RIDX_W-1:0] rdIdx,
  input  logic [RIDX_W-1:0] raIdx,
  input  logic [RIDX_W-1:0] rbIdx,
  input  logic [WORD_W-1:0] memRdata,
  output logic [WORD_W-1:0] memWdata,
  output logic [ACC_W:0]    macSum
);

  logic [LANE_W-1:0]       laneWord [LANES];
  logic signed [ACC_W-1:0] laneAcc  [LANES];

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [LANE_W-1:0]         rf [NREG];
    logic signed [ACC_W-1:0]   acc;
    logic                      laneOn;
    logic [LANE_W-1:0]         half;
    logic [LANE_W-1:0]         ldVal;
    logic signed [LANE_W-1:0]  prod;

    assign laneOn = (ln == 0) || strobe.simd;
    assign half   = memRdata[LANE_W*ln +: LANE_W];
    assign ldVal  = strobe.bcast ? memRdata[LANE_W-1:0] : half;
    assign prod   = $signed(half[HALF_W-1:0]) * $signed(half[LANE_W-1:HALF_W]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < NREG; i++) rf[i] <= '0;
        acc <= '0;
      end else begin
        if (laneOn && strobe.ldWr)  rf[rdIdx] <= ldVal;
        if (laneOn && strobe.addWr) rf[rdIdx] <= rf[raIdx] + rf[rbIdx];
        if (strobe.accClr)
          acc <= '0;
        else if (laneOn && strobe.macStep)
          acc <= acc + {{(ACC_W-LANE_W){prod[LANE_W-1]}}, prod};
      end
    end

    assign laneWord[ln] = rf[rdIdx];
    assign laneAcc[ln]  = acc;
  end

  assign memWdata = {laneWord[1], laneWord[0]};
  assign macSum   = {laneAcc[0][ACC_W-1], laneAcc[0]} + {laneAcc[1][ACC_W-1], laneAcc[1]};

endmodule

// File: rtl/simd_pair_dp.sv
module simd_pair_dp
  import simd_pair_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8,
  parameter int ACC_W  = 40,
  localparam int RIDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              simdEn,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdOp,
  input  logic              cmdBcast,
  input  logic [RIDX_W-1:0] cmdRd,
  input  logic [RIDX_W-1:0] cmdRa,
  input  logic [RIDX_W-1:0] cmdRb,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [CNT_W-1:0]  cmdCount,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [1:0]        memWmask,
  output logic [63:0]       memWdata,
  input  logic [63:0]       memRdata,
  output logic [ACC_W:0]    macSum,
  output logic              doneFlag
);

  lane_strobe_t      strobe;
  logic [RIDX_W-1:0] rdIdx;
  logic [RIDX_W-1:0] raIdx;
  logic [RIDX_W-1:0] rbIdx;

  simd_pair_ctrl #(
    .NREG(NREG), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .simdEn(simdEn),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp),
    .cmdBcast(cmdBcast), .cmdRd(cmdRd), .cmdRa(cmdRa), .cmdRb(cmdRb),
    .cmdAddr(cmdAddr), .cmdCount(cmdCount),
    .memAddr(memAddr), .memRe(memRe), .memWe(memWe), .memWmask(memWmask),
    .doneFlag(doneFlag), .strobe(strobe),
    .rdIdx(rdIdx), .raIdx(raIdx), .rbIdx(rbIdx)
  );

  simd_pair_lanes #(
    .NREG(NREG), .ACC_W(ACC_W)
  ) u_lanes (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rdIdx(rdIdx), .raIdx(raIdx), .rbIdx(rbIdx),
    .memRdata(memRdata), .memWdata(memWdata), .macSum(macSum)
  );

endmodule

// File: rtl/simd_pair_chk.sv
module simd_pair_chk #(
  parameter int ACC_W = 40
) (
  input logic           clk,
  input logic           rstN,
  input logic           cmdValid,
  input logic           cmdReady,
  input logic           memRe,
  input logic           memWe,
  input logic [1:0]     memWmask,
  input logic           doneFlag,
  input logic [ACC_W:0] macSum
);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |=> !doneFlag);

  // R10
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdReady);

  // R10
  done_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |-> !cmdReady);

  // R5
  store_low_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memWmask[0]);

  // R5
  store_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);

  // R5
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe));

  // R7
  idle_sum_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReady && !cmdValid) |=> $stable(macSum));

  // R11
  no_read_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !memRe);

endmodule

bind simd_pair_dp simd_pair_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .memRe(memRe), .memWe(memWe), .memWmask(memWmask),
  .doneFlag(doneFlag), .macSum(macSum)
);

// File: tb/simd_pair_dp_bench.sv
`timescale 1ns/1ps
module simd_pair_dp_bench;

  localparam int ACC_W = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        simdEn = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [1:0]  cmdOp = '0;
  logic        cmdBcast = 1'b0;
  logic [2:0]  cmdRd = '0, cmdRa = '0, cmdRb = '0;
  logic [7:0]  cmdAddr = '0;
  logic [7:0]  cmdCount = '0;
  logic [7:0]  memAddr;
  logic        memRe, memWe;
  logic [1:0]  memWmask;
  logic [63:0] memWdata;
  logic [63:0] memRdata = '0;
  logic [ACC_W:0] macSum;
  logic        doneFlag;

  logic [63:0] mem [256];
  int readCnt = 0;
  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  simd_pair_dp u_simd_pair_dp (
    .clk(clk), .rstN(rstN), .simdEn(simdEn), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdOp(cmdOp), .cmdBcast(cmdBcast),
    .cmdRd(cmdRd), .cmdRa(cmdRa), .cmdRb(cmdRb), .cmdAddr(cmdAddr),
    .cmdCount(cmdCount), .memAddr(memAddr), .memRe(memRe), .memWe(memWe),
    .memWmask(memWmask), .memWdata(memWdata), .memRdata(memRdata),
    .macSum(macSum), .doneFlag(doneFlag)
  );

  function automatic logic [63:0] pat(input int i);
    logic [15:0] s0, c0, s1, c1;
    s0 = 16'(i*3 - 20);
    c0 = 16'(7 - i);
    s1 = 16'(9 - i*5);
    c1 = 16'(i*11 - 100);
    return {c1, s1, c0, s0};
  endfunction

  // memory model: one cycle read latency, masked halves on write
  always @(posedge clk) begin
    if (memRe) begin
      memRdata <= mem[memAddr];
      readCnt  <= readCnt + 1;
    end
    if (memWe) begin
      if (memWmask[0]) mem[memAddr][31:0]  <= memWdata[31:0];
      if (memWmask[1]) mem[memAddr][63:32] <= memWdata[63:32];
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runCmd(input logic [1:0] op, input logic bc, input logic sm,
                        input logic [2:0] rd, input logic [2:0] ra, input logic [2:0] rb,
                        input logic [7:0] ad, input logic [7:0] cnt,
                        output int cyc, output int rds);
    int r0;
    @(negedge clk);
    cmdOp = op; cmdBcast = bc; simdEn = sm; cmdRd = rd; cmdRa = ra; cmdRb = rb;
    cmdAddr = ad; cmdCount = cnt; cmdValid = 1'b1;
    r0 = readCnt;
    @(negedge clk);
    cmdValid = 1'b0;
    cyc = 1;
    while (!doneFlag && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    @(negedge clk);
    rds = readCnt - r0;
  endtask

  function automatic longint expMac(input logic sm, input int ad, input int cnt);
    longint s = 0;
    for (int w = ad; w < ad + cnt; w++) begin
      s += longint'($signed(mem[w][15:0])) * longint'($signed(mem[w][31:16]));
      if (sm) s += longint'($signed(mem[w][47:32])) * longint'($signed(mem[w][63:48]));
    end
    return s;
  endfunction

  // {simd, start address, count}
  localparam logic [16:0] MAC_VEC [5] = '{
    {1'b1, 8'h10, 8'd4},
    {1'b1, 8'h20, 8'd1},
    {1'b0, 8'h10, 8'd4},
    {1'b1, 8'h30, 8'd8},
    {1'b0, 8'h18, 8'd3}
  };

  initial begin
    #2_000_000;
    nChecks++;
    nFails++;
    $display("FAIL R9 watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int cyc, rds;
    longint ex;
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    mem[9]    = 64'hFFFF_FFFF_8000_0001;
    mem[8'hC4] = 64'hDEAD_BEEF_0123_4567;
    mem[8'hC9] = '1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 cmdReady", 64'(cmdReady), 64'd1);
    check("R1 doneFlag", 64'(doneFlag), 64'd0);
    check("R1 memRe/memWe", {62'd0, memRe, memWe}, 64'd0);
    check("R1 macSum", 64'(macSum), 64'd0);
    runCmd(2'd1, 1'b0, 1'b1, 3'd7, 3'd0, 3'd0, 8'hC9, 8'd0, cyc, rds);
    check("R1 registers zero", mem[8'hC9], 64'd0);

    // R7 R8 R9 R11 table walk
    for (int v = 0; v < 5; v++) begin
      logic sm;
      logic [7:0] ad, ct;
      {sm, ad, ct} = MAC_VEC[v];
      ex = expMac(sm, int'(ad), int'(ct));
      runCmd(2'd3, 1'b0, sm, 3'd0, 3'd0, 3'd0, ad, ct, cyc, rds);
      check(sm ? "R7 macSum" : "R8 macSum lane0 only", 64'(macSum), 64'(ex[ACC_W:0]));
      check("R11 read count", 64'(rds), 64'(ct));
      check("R9 done cycle", 64'(cyc), 64'(int'(ct) + 1));
    end

    // R9 zero count
    runCmd(2'd3, 1'b0, 1'b1, 3'd0, 3'd0, 3'd0, 8'h10, 8'd0, cyc, rds);
    check("R9 zero count sum", 64'(macSum), 64'd0);
    check("R9 zero count done cycle", 64'(cyc), 64'd1);
    check("R9 zero count reads", 64'(rds), 64'd0);

    // R2 paired load
    runCmd(2'd0, 1'b0, 1'b1, 3'd1, 3'd0, 3'd0, 8'h05, 8'd0, cyc, rds);
    check("R9 load done cycle", 64'(cyc), 64'd2);
    check("R11 load reads", 64'(rds), 64'd1);
    runCmd(2'd1, 1'b0, 1'b1, 3'd1, 3'd0, 3'd0, 8'hC0, 8'd0, cyc, rds);
    check("R2 paired load", mem[8'hC0], pat(5));

    // R3 broadcast load
    runCmd(2'd0, 1'b1, 1'b1, 3'd2, 3'd0, 3'd0, 8'h06, 8'd0, cyc, rds);
    runCmd(2'd1, 1'b0, 1'b1, 3'd2, 3'd0, 3'd0, 8'hC1, 8'd0, cyc, rds);
    check("R3 broadcast load", mem[8'hC1], {pat(6)[31:0], pat(6)[31:0]});

    // R4 lane 1 untouched when mode off
    runCmd(2'd0, 1'b0, 1'b0, 3'd2, 3'd0, 3'd0, 8'h07, 8'd0, cyc, rds);
    runCmd(2'd1, 1'b0, 1'b1, 3'd2, 3'd0, 3'd0, 8'hC2, 8'd0, cyc, rds);
    check("R4 paired load lane0 only", mem[8'hC2], {pat(6)[31:0], pat(7)[31:0]});
    runCmd(2'd0, 1'b1, 1'b0, 3'd3, 3'd0, 3'd0, 8'h08, 8'd0, cyc, rds);
    runCmd(2'd1, 1'b0, 1'b1, 3'd3, 3'd0, 3'd0, 8'hC3, 8'd0, cyc, rds);
    check("R4 broadcast lane0 only", mem[8'hC3], {32'd0, pat(8)[31:0]});

    // R5 non-SIMD store keeps high half
    runCmd(2'd1, 1'b0, 1'b0, 3'd1, 3'd0, 3'd0, 8'hC4, 8'd0, cyc, rds);
    check("R5 low-half store", mem[8'hC4], {32'hDEAD_BEEF, pat(5)[31:0]});

    // R6 lane-parallel add
    runCmd(2'd2, 1'b0, 1'b1, 3'd4, 3'd1, 3'd2, 8'h00, 8'd0, cyc, rds);
    runCmd(2'd1, 1'b0, 1'b1, 3'd4, 3'd0, 3'd0, 8'hC5, 8'd0, cyc, rds);
    check("R6 complex add", mem[8'hC5],
          {pat(5)[63:32] + pat(6)[31:0], pat(5)[31:0] + pat(7)[31:0]});
    runCmd(2'd2, 1'b0, 1'b0, 3'd5, 3'd1, 3'd1, 8'h00, 8'd0, cyc, rds);
    runCmd(2'd1, 1'b0, 1'b1, 3'd5, 3'd0, 3'd0, 8'hC6, 8'd0, cyc, rds);
    check("R4 add lane0 only", mem[8'hC6], {32'd0, pat(5)[31:0] + pat(5)[31:0]});
    runCmd(2'd0, 1'b0, 1'b1, 3'd6, 3'd0, 3'd0, 8'h09, 8'd0, cyc, rds);
    runCmd(2'd2, 1'b0, 1'b1, 3'd6, 3'd6, 3'd6, 8'h00, 8'd0, cyc, rds);
    runCmd(2'd1, 1'b0, 1'b1, 3'd6, 3'd0, 3'd0, 8'hC7, 8'd0, cyc, rds);
    check("R6 add wrap", mem[8'hC7], 64'hFFFF_FFFE_0000_0002);

    // R10 command while busy is ignored
    @(negedge clk);
    cmdOp = 2'd3; simdEn = 1'b1; cmdAddr = 8'h10; cmdCount = 8'd6; cmdValid = 1'b1;
    @(negedge clk);
    check("R10 busy not ready", 64'(cmdReady), 64'd0);
    cmdOp = 2'd0; cmdBcast = 1'b1; cmdRd = 3'd1; cmdAddr = 8'h0A;
    @(negedge clk);
    cmdValid = 1'b0;
    cyc = 0;
    while (!doneFlag && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    @(negedge clk);
    check("R10 ready after done", 64'(cmdReady), 64'd1);
    runCmd(2'd1, 1'b0, 1'b1, 3'd1, 3'd0, 3'd0, 8'hC8, 8'd0, cyc, rds);
    check("R10 ignored load", mem[8'hC8], pat(5));

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule